// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block produces the system reset for a digital domain. It combines a supply-low flag from an external comparator, a debounced active-low pushbutton or logic reset request, and a software watchdog into one reset line. Release is held back by a fixed hold-off time, so downstream logic always sees a reset pulse of known length. All intervals are counted in clock ticks.

The watchdog expects software to toggle a strobe pin. Both rising and falling edges count as service. If no edge arrives within the watchdog period, the block takes one of two actions, chosen by a mode pin. It can raise a full-length system reset. It can instead pull a separate active-low fault line, which stays low until the strobe moves again or a reset occurs. The watchdog is held idle while the system runs from its backup battery, and while an external detector reports that the strobe pin is floating.

The pushbutton and strobe inputs pass through two-flop synchronizers. The supply-low, battery-mode, floating-strobe and mode inputs are taken to be synchronous to `clk`.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While `supply_low` is 1, `sys_rst` is 1 from the clock edge after it is seen.
- R2: `mrst_n` held at 0 for at least GLITCH_TICKS clocks asserts `sys_rst` within SYNC_STAGES+GLITCH_TICKS+1 clocks.
- R3: A low pulse on `mrst_n` that lasts fewer than GLITCH_TICKS clocks leaves `sys_rst` at 0.
- R4: Once every reset cause has gone, `sys_rst` stays 1 for exactly RST_TICKS further clock edges and then falls.
- R5: While `por_n` is 0, `sys_rst` is 1 and `wd_fault_n` is 1. After `por_n` rises, `sys_rst` falls on the RST_TICKS-th clock edge.
- R6: `sys_rst_n` is always the inverse of `sys_rst`.
- R7: With the watchdog active and no strobe edge, a timeout fires WD_TICKS clocks after the count last restarted. A rising edge or a falling edge of `wd_strobe` restarts the count.
- R8: With `wd_pulse_mode`=1, a timeout produces a `sys_rst` pulse of RST_TICKS clocks, and `wd_fault_n` stays 1.
- R9: With `wd_pulse_mode`=0, a timeout drives `wd_fault_n` to 0. It returns to 1 on the next strobe edge, or on the edge after `sys_rst` is seen at 1.
- R10: While `batt_mode`=1 or `wd_float`=1, no timeout occurs, the count is cleared, and `wd_fault_n` is 1.
- R11: The watchdog count is held cleared while `sys_rst` is 1. After reset release, a fresh full period is needed before a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| supply_low | input | 1 | Supply below threshold flag, active high |
| mrst_n | input | 1 | Manual reset request, active low, asynchronous |
| wd_strobe | input | 1 | Watchdog service strobe, asynchronous |
| wd_float | input | 1 | Strobe pin detected as unconnected or three-stated |
| batt_mode | input | 1 | System is running from the backup battery |
| wd_pulse_mode | input | 1 | 1: a timeout pulses the system reset; 0: a timeout drives the fault output |
| sys_rst | output | 1 | System reset, active high |
| sys_rst_n | output | 1 | System reset, active low |
| wd_fault_n | output | 1 | Watchdog fault, active low |

## Verification
The bench builds the block with RST_TICKS=8, WD_TICKS=20 and GLITCH_TICKS=3, in place of the millisecond-scale defaults. With these values a complete watchdog timeout, the reset pulse it triggers, and the next timeout all happen within a few dozen clocks. The exact release edge of the hold-off counter, and the one-clock boundary between a rejected and an accepted pushbutton pulse, can then be checked against computed cycle numbers. The short periods also make repeated pulsed-mode cycles and mode changes in the middle of a reset cheap to run in sequence.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic {
    WD_ACT_FAULT_PIN = 1'b0,
    WD_ACT_SYS_RESET = 1'b1
  } wd_action_e;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain[0] <= RESET_VAL;
    else         chain[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain[i] <= RESET_VAL;
      else         chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/sup_mr_filter.sv
module sup_mr_filter
  import sup_pkg::*;
#(
  parameter int unsigned WINDOW = 5
) (
  input  logic clk,
  input  logic arst_n,
  input  logic mr_n_sync,
  output logic mr_active
);
  localparam int unsigned CW = cnt_width(WINDOW);
  localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

  logic [CW-1:0] low_cnt;

  // Asserts only after WINDOW consecutive low samples; releases at once.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      low_cnt   <= '0;
      mr_active <= 1'b0;
    end else if (mr_n_sync) begin
      low_cnt   <= '0;
      mr_active <= 1'b0;
    end else if (!mr_active) begin
      if (low_cnt == LAST) mr_active <= 1'b1;
      else                 low_cnt   <= low_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sup_rst_stretch.sv
module sup_rst_stretch
  import sup_pkg::*;
#(
  parameter int unsigned HOLD = 8
) (
  input  logic clk,
  input  logic arst_n,
  input  logic cause,
  output logic rst_out
);
  localparam int unsigned CW = cnt_width(HOLD);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] hold_cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      hold_cnt <= '0;
      rst_out  <= 1'b1;
    end else if (cause) begin
      hold_cnt <= '0;
      rst_out  <= 1'b1;
    end else if (rst_out) begin
      if (hold_cnt == LAST) begin
        hold_cnt <= '0;
        rst_out  <= 1'b0;
      end else begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sup_watchdog.sv
module sup_watchdog
  import sup_pkg::*;
#(
  parameter int unsigned PERIOD = 20
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       strobe_sync,
  input  logic       inhibit,
  input  logic       hold_clear,
  input  wd_action_e action,
  output logic       reset_req,
  output logic       fault_n
);
  localparam int unsigned CW = cnt_width(PERIOD);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] wd_cnt;
  logic          strobe_q;
  logic          strobe_edge;

  assign strobe_edge = strobe_sync ^ strobe_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      wd_cnt    <= '0;
      strobe_q  <= 1'b0;
      reset_req <= 1'b0;
      fault_n   <= 1'b1;
    end else begin
      strobe_q  <= strobe_sync;
      reset_req <= 1'b0;
      if (hold_clear || inhibit || strobe_edge) begin
        wd_cnt  <= '0;
        fault_n <= 1'b1;
      end else if (!fault_n) begin
        wd_cnt <= '0;
      end else if (wd_cnt == LAST) begin
        wd_cnt <= '0;
        if (action == WD_ACT_SYS_RESET) reset_req <= 1'b1;
        else                            fault_n   <= 1'b0;
      end else begin
        wd_cnt <= wd_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl
  import sup_pkg::*;
#(
  parameter int unsigned RST_TICKS    = 10_000_000,
  parameter int unsigned WD_TICKS     = 60_000_000,
  parameter int unsigned GLITCH_TICKS = 5,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic supply_low,
  input  logic mrst_n,
  input  logic wd_strobe,
  input  logic wd_float,
  input  logic batt_mode,
  input  logic wd_pulse_mode,
  output logic sys_rst,
  output logic sys_rst_n,
  output logic wd_fault_n
);
  logic mr_n_s, strobe_s, mr_act, wd_req, rst_q;
  wd_action_e wd_action;

  assign wd_action = wd_action_e'(wd_pulse_mode);

  sup_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_mr_sync (
    .clk(clk), .arst_n(por_n), .d(mrst_n), .q(mr_n_s)
  );

  sup_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_strobe_sync (
    .clk(clk), .arst_n(por_n), .d(wd_strobe), .q(strobe_s)
  );

  sup_mr_filter #(.WINDOW(GLITCH_TICKS)) u_mr_filter (
    .clk(clk), .arst_n(por_n), .mr_n_sync(mr_n_s), .mr_active(mr_act)
  );

  sup_watchdog #(.PERIOD(WD_TICKS)) u_watchdog (
    .clk(clk), .arst_n(por_n), .strobe_sync(strobe_s),
    .inhibit(batt_mode | wd_float), .hold_clear(rst_q),
    .action(wd_action), .reset_req(wd_req), .fault_n(wd_fault_n)
  );

  sup_rst_stretch #(.HOLD(RST_TICKS)) u_stretch (
    .clk(clk), .arst_n(por_n), .cause(supply_low | mr_act | wd_req),
    .rst_out(rst_q)
  );

  assign sys_rst   = rst_q;
  assign sys_rst_n = ~rst_q;
endmodule

// File: rtl/sup_reset_ctrl_chk.sv
module sup_reset_ctrl_chk #(
  parameter int unsigned RST_TICKS = 8
) (
  input logic clk,
  input logic por_n,
  input logic supply_low,
  input logic batt_mode,
  input logic wd_float,
  input logic wd_pulse_mode,
  input logic sys_rst,
  input logic sys_rst_n,
  input logic wd_fault_n
);
  localparam int unsigned QW = $clog2(RST_TICKS + 1) + 1;
  logic [QW-1:0] quiet_cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                      quiet_cnt <= '0;
    else if (supply_low)             quiet_cnt <= '0;
    else if (quiet_cnt < QW'(RST_TICKS)) quiet_cnt <= quiet_cnt + 1'b1;
  end

  // R1
  supply_forces_reset_chk: assert property (@(posedge clk) disable iff (!por_n)
    supply_low |=> sys_rst);

  // R4
  release_after_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sys_rst) |-> quiet_cnt >= QW'(RST_TICKS));

  // R10
  inhibit_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
    (batt_mode || wd_float) |=> wd_fault_n);

  // R8
  pulse_mode_pin_high_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wd_pulse_mode && wd_fault_n) |=> wd_fault_n);

  // R9
  reset_clears_fault_chk: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst |=> wd_fault_n);

  // R6
  polarity_pair_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst) |-> $fell(sys_rst_n));
endmodule

bind sup_reset_ctrl sup_reset_ctrl_chk #(.RST_TICKS(RST_TICKS)) u_sup_chk (
  .clk(clk), .por_n(por_n), .supply_low(supply_low), .batt_mode(batt_mode),
  .wd_float(wd_float), .wd_pulse_mode(wd_pulse_mode), .sys_rst(sys_rst),
  .sys_rst_n(sys_rst_n), .wd_fault_n(wd_fault_n)
);

// File: tb/test_sup_reset_ctrl.sv
module test_sup_reset_ctrl;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned RST = 8;
  localparam int unsigned WD  = 20;
  localparam int unsigned GL  = 3;

  logic clk = 1'b0;
  logic por_n = 1'b0, supply_low = 1'b0, mrst_n = 1'b1, wd_strobe = 1'b0;
  logic wd_float = 1'b0, batt_mode = 1'b0, wd_pulse_mode = 1'b0;
  logic sys_rst, sys_rst_n, wd_fault_n;
  int nvec = 0, nbad = 0;

  always #10 clk = ~clk;

  sup_reset_ctrl #(.RST_TICKS(RST), .WD_TICKS(WD), .GLITCH_TICKS(GL)) i_sup_reset_ctrl (
    .clk(clk), .por_n(por_n), .supply_low(supply_low), .mrst_n(mrst_n),
    .wd_strobe(wd_strobe), .wd_float(wd_float), .batt_mode(batt_mode),
    .wd_pulse_mode(wd_pulse_mode), .sys_rst(sys_rst), .sys_rst_n(sys_rst_n),
    .wd_fault_n(wd_fault_n)
  );

  typedef struct packed {
    logic sl; logic mr_n; logic batt; logic flt; logic pm;
    logic [9:0] cyc; logic er; logic ef;
  } vec_t;

  localparam vec_t TBL [18] = '{
    '{1'b1,1'b1,1'b0,1'b0,1'b0,10'd4 ,1'b1,1'b1},  // R1
    '{1'b0,1'b1,1'b0,1'b0,1'b0,10'd4 ,1'b1,1'b1},  // R4 still held
    '{1'b0,1'b1,1'b0,1'b0,1'b0,10'd8 ,1'b0,1'b1},  // R4 released
    '{1'b0,1'b1,1'b1,1'b0,1'b0,10'd40,1'b0,1'b1},  // R10 battery
    '{1'b0,1'b1,1'b0,1'b1,1'b0,10'd40,1'b0,1'b1},  // R10 floating
    '{1'b0,1'b1,1'b0,1'b0,1'b0,10'd25,1'b0,1'b0},  // R7 R9 timeout
    '{1'b0,1'b1,1'b1,1'b0,1'b0,10'd2 ,1'b0,1'b1},  // R10 releases fault
    '{1'b0,1'b1,1'b0,1'b0,1'b0,10'd10,1'b0,1'b1},
    '{1'b1,1'b1,1'b0,1'b0,1'b0,10'd2 ,1'b1,1'b1},  // R1
    '{1'b0,1'b1,1'b0,1'b0,1'b0,10'd30,1'b0,1'b0},  // R11 R7
    '{1'b0,1'b0,1'b0,1'b0,1'b0,10'd10,1'b1,1'b1},  // R2 R9 reset clears fault
    '{1'b0,1'b1,1'b0,1'b0,1'b0,10'd14,1'b0,1'b1},
    '{1'b0,1'b1,1'b0,1'b0,1'b1,10'd10,1'b0,1'b1},
    '{1'b0,1'b1,1'b0,1'b0,1'b1,10'd12,1'b1,1'b1},  // R8 pulse
    '{1'b0,1'b1,1'b0,1'b0,1'b1,10'd20,1'b0,1'b1},  // R8 pulse ended
    '{1'b0,1'b1,1'b0,1'b0,1'b1,10'd10,1'b1,1'b1},  // R8 repeats
    '{1'b0,1'b1,1'b0,1'b0,1'b0,10'd10,1'b0,1'b1},
    '{1'b0,1'b1,1'b0,1'b0,1'b0,10'd18,1'b0,1'b0}   // R9 R11
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_out(input string req, input logic er, input logic ef);
    chk({req, " sys_rst"}, sys_rst, er);
    chk("R6 sys_rst_n", sys_rst_n, ~er);
    chk({req, " wd_fault_n"}, wd_fault_n, ef);
  endtask

  initial begin
    #(20 * 150000);
    nbad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic seen;
    // R5: power-on state and exact release
    tick(3);
    chk_out("R5", 1'b1, 1'b1);
    por_n = 1'b1;
    tick(RST - 1);
    chk_out("R5", 1'b1, 1'b1);
    tick(1);
    chk_out("R5", 1'b0, 1'b1);
    tick(2);

    for (int i = 0; i < 18; i++) begin
      supply_low = TBL[i].sl; mrst_n = TBL[i].mr_n; batt_mode = TBL[i].batt;
      wd_float = TBL[i].flt; wd_pulse_mode = TBL[i].pm;
      tick(int'(TBL[i].cyc));
      chk_out($sformatf("R7 vec%0d", i), TBL[i].er, TBL[i].ef);
    end

    // R9 R7: rising strobe edge clears the fault, then falling edge does
    wd_strobe = 1'b1;
    tick(4);
    chk("R9 rising edge clears", wd_fault_n, 1'b1);
    tick(WD + 2);
    chk("R7 timeout after rise", wd_fault_n, 1'b0);
    wd_strobe = 1'b0;
    tick(4);
    chk("R9 falling edge clears", wd_fault_n, 1'b1);

    // R7: regular service keeps watchdog quiet, both modes
    for (int k = 0; k < 8; k++) begin
      wd_strobe = ~wd_strobe;
      tick(8);
      chk_out("R7 serviced output mode", 1'b0, 1'b1);
    end
    wd_pulse_mode = 1'b1;
    for (int k = 0; k < 8; k++) begin
      wd_strobe = ~wd_strobe;
      tick(8);
      chk_out("R7 serviced pulse mode", 1'b0, 1'b1);
    end
    wd_pulse_mode = 1'b0;

    // R4: exact hold-off length after supply recovers
    supply_low = 1'b1;
    tick(3);
    supply_low = 1'b0;
    tick(RST - 1);
    chk("R4 one before release", sys_rst, 1'b1);
    tick(1);
    chk("R4 release edge", sys_rst, 1'b0);

    // R3: short manual pulse ignored
    wd_strobe = ~wd_strobe;
    mrst_n = 1'b0;
    tick(GL - 1);
    mrst_n = 1'b1;
    seen = 1'b0;
    for (int k = 0; k < 12; k++) begin
      tick(1);
      if (sys_rst) seen = 1'b1;
    end
    chk("R3 short pulse ignored", seen, 1'b0);

    // R2: pulse of exactly the window is accepted
    mrst_n = 1'b0;
    tick(GL);
    mrst_n = 1'b1;
    tick(4);
    chk("R2 window pulse accepted", sys_rst, 1'b1);
    tick(RST + 4);
    chk("R4 release after manual", sys_rst, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule